// File: doc/BRIEF.md
# Asynchronous Level Synchronizer with Rise Pulse

This block carries one single-bit level signal, for example an unfiltered push-button line, from outside any clock domain into the domain of `clk_i`. The raw input feeds the first of a chain of flip-flops. Each later flip-flop in the chain samples the one before it on the same rising edge. The chain is two or three stages deep, set by a parameter. The synchronized level is taken only from the last stage. The first stage may go metastable, and nothing outside the chain ever sees it.

A two-stage chain gives a metastable first stage one full clock period to settle. A three-stage chain gives it two periods and is meant for very fast clocks. One more flip-flop holds the synchronized level from the previous cycle. The block ANDs the current level with the inverse of that delayed copy. This gives a pulse one clock wide for every low-to-high change of the synchronized level, in the same cycle as that change. Logic downstream can treat the pulse as a single "pressed" event.

Top module: `btn_sync_pulse`

## Requirements
- R1: The parameter `SYNC_DEPTH` accepts only 2 or 3, and any other value stops elaboration with an error. With depth 2 the output latency is two cycles, and with depth 3 it is three cycles.
- R2: While `rst_ni` is 0, every synchronizer stage and the delay flop are 0. As a result `level_o` and `rise_o` both read 0, whatever `async_i` does.
- R3: If `async_i` changes well clear of a rising edge of `clk_i`, `level_o` takes the new value exactly `SYNC_DEPTH` rising edges later. The first edge after the change counts as edge 1.
- R4: If `async_i` changes at any offset within the clock period, `level_o` follows after `SYNC_DEPTH` or `SYNC_DEPTH`+1 edges.
- R5: `rise_o` is 1 in the same cycle that `level_o` first reads 1 after reading 0, and it is 0 in the cycle that follows.
- R6: After reset is released with `async_i` at 0, `rise_o` stays 0.
- R7: If `async_i` stays at 1, the block gives exactly one pulse. Each further pulse needs `level_o` to return to 0 and then rise again, so the pulse count equals the number of rising level changes.
- R8: A change of `level_o` from 1 to 0 produces no pulse on `rise_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of the destination domain; all flops capture on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all stages and the delay flop |
| async_i | input | 1 | Raw level with no timing relation to `clk_i` |
| level_o | output | 1 | Synchronized level, taken from the last stage |
| rise_o | output | 1 | One-cycle pulse on each low-to-high change of `level_o` |

## Verification
The assertions rely on `async_i` being sampled at a definite 0 or 1 at each clock edge. They do not model metastable settling, so the delay check compares the output against the input history exactly `SYNC_DEPTH` edges back. The bench stays within that assumption by moving `async_i` only at whole-nanosecond offsets that avoid the clock edge itself. It still spreads those offsets across the period and accepts one extra cycle only where the offset is random. Each level change is held longer than the chain depth, so every rise reaches `level_o` and is counted.

// File: rtl/sync_pkg.sv
package sync_pkg;

   localparam int unsigned SYNC_DEPTH_MIN = 2;
   localparam int unsigned SYNC_DEPTH_MAX = 3;

   // legal depths of the synchronizing chain
   function automatic bit depth_ok(input int unsigned depth);
      return (depth >= SYNC_DEPTH_MIN) && (depth <= SYNC_DEPTH_MAX);
   endfunction

   // width of a counter that must reach 'limit'
   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   output logic dout_o
);
   localparam int unsigned LAST = DEPTH - 1;
   localparam int unsigned WARM_W = sync_pkg::cnt_width(DEPTH);

   logic [DEPTH-1:0] stage_q;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_first
            // only flop that sees the raw asynchronous input
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[0] <= 1'b0;
               else         stage_q[0] <= din_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[i] <= 1'b0;
               else         stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign dout_o = stage_q[LAST];

   // checker state: edges since reset release, saturating at DEPTH
   logic [WARM_W-1:0] warm_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  warm_q <= '0;
      else if (warm_q < WARM_W'(DEPTH)) warm_q <= warm_q + 1'b1;
   end

   assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == WARM_W'(DEPTH)) |-> (dout_o == $past(din_i, DEPTH)))
      else $error("level_o does not follow async_i by DEPTH edges");

endmodule

// File: rtl/rise_detect.sv
module rise_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   output logic rise_o
);
   logic level_d_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) level_d_q <= 1'b0;
      else         level_d_q <= level_i;
   end

   assign rise_o = level_i & ~level_d_q;

   assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o)
      else $error("rise pulse wider than one cycle");

   assert_no_fall_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(level_i) |-> !rise_o)
      else $error("pulse on falling level");

endmodule

// File: rtl/btn_sync_pulse.sv
module btn_sync_pulse #(
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   generate
      if (!sync_pkg::depth_ok(SYNC_DEPTH)) begin : g_bad_depth
         $error("SYNC_DEPTH must be 2 or 3");
      end
   endgenerate

   logic sync_level;
   logic rise_pulse;

   sync_chain #(
      .DEPTH (SYNC_DEPTH)
   ) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (async_i),
      .dout_o (sync_level)
   );

   rise_detect u_rise (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (sync_level),
      .rise_o  (rise_pulse)
   );

   assign level_o = sync_level;
   assign rise_o  = rise_pulse;

   assert_reset_clear_R2: assert property (@(posedge clk_i)
      !rst_ni |-> (!level_o && !rise_o))
      else $error("outputs not cleared in reset");

   assert_rise_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(level_o) |-> rise_o)
      else $error("level rose without a pulse");

   assert_pulse_needs_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> (level_o && !$past(level_o)))
      else $error("pulse without a low-to-high level change");

   assert_release_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> !rise_o)
      else $error("pulse at reset release");

endmodule

// File: tb/btn_sync_pulse_bench.sv
module btn_sync_pulse_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic async_in = 1'b0;
   logic lvl2, rise2, lvl3, rise3;
   int   checks = 0;
   int   errors = 0;
   int   pcnt2 = 0;
   int   pcnt3 = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   btn_sync_pulse #(.SYNC_DEPTH(2)) u_btn_sync_pulse (
      .clk_i(clk), .rst_ni(rst_n), .async_i(async_in), .level_o(lvl2), .rise_o(rise2));

   btn_sync_pulse #(.SYNC_DEPTH(3)) u_btn_sync_pulse_d3 (
      .clk_i(clk), .rst_ni(rst_n), .async_i(async_in), .level_o(lvl3), .rise_o(rise3));

   always @(negedge clk) begin
      if (rise2) pcnt2++;
      if (rise3) pcnt3++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // changes async_in at offset 'off' after an edge, returns latency of both copies
   task automatic move_input(input bit val, input int off, output int lat2, output int lat3,
                             output int pulse_at2, output int pulse_at3, output int pulse_after2);
      lat2 = -1; lat3 = -1; pulse_at2 = -1; pulse_at3 = -1; pulse_after2 = -1;
      @(posedge clk);
      #(off);
      async_in = val;
      for (int c = 1; c <= 8; c++) begin
         @(posedge clk);
         #2;
         if (lat2 < 0 && lvl2 == val) begin lat2 = c; pulse_at2 = rise2; end
         else if (lat2 > 0 && pulse_after2 < 0) pulse_after2 = rise2;
         if (lat3 < 0 && lvl3 == val) begin lat3 = c; pulse_at3 = rise3; end
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #3; async_in = ~async_in;
         @(negedge clk);
         check("R2 level in reset", lvl2, 0);
         check("R2 pulse in reset", rise2 | rise3, 0);
      end
      async_in = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R6 no pulse after release", rise2 | rise3, 0);
      end
      check("R6 level stays low", lvl2 | lvl3, 0);
   endtask

   task automatic t_fixed_latency();
      int l2, l3, p2, p3, pa;
      move_input(1'b1, 10, l2, l3, p2, p3, pa);
      check("R3 depth2 rise latency", l2, 2);
      check("R1 depth3 rise latency", l3, 3);
      check("R5 pulse with level rise depth2", p2, 1);
      check("R5 pulse with level rise depth3", p3, 1);
      check("R5 pulse gone next cycle", pa, 0);
      move_input(1'b0, 10, l2, l3, p2, p3, pa);
      check("R3 depth2 fall latency", l2, 2);
      check("R1 depth3 fall latency", l3, 3);
      check("R8 no pulse on fall", p2 | p3, 0);
   endtask

   task automatic t_hold_high();
      int base2 = pcnt2;
      int base3 = pcnt3;
      int l2, l3, p2, p3, pa;
      move_input(1'b1, 7, l2, l3, p2, p3, pa);
      repeat (20) @(posedge clk);
      #2;
      check("R7 single pulse while held depth2", pcnt2 - base2, 1);
      check("R7 single pulse while held depth3", pcnt3 - base3, 1);
      move_input(1'b0, 13, l2, l3, p2, p3, pa);
      check("R8 fall adds no pulse", pcnt2 - base2, 1);
   endtask

   task automatic t_random_offsets();
      int base2 = pcnt2;
      int base3 = pcnt3;
      int rises = 0;
      int l2, l3, p2, p3, pa;
      for (int k = 0; k < 24; k++) begin
         bit v = (k % 2 == 0);
         int off = $urandom_range(1, 19);
         move_input(v, off, l2, l3, p2, p3, pa);
         if (v) rises++;
         check("R4 depth2 latency in range", (l2 == 2 || l2 == 3) ? 1 : 0, 1);
         check("R4 depth3 latency in range", (l3 == 3 || l3 == 4) ? 1 : 0, 1);
      end
      check("R7 pulse count equals rises depth2", pcnt2 - base2, rises);
      check("R7 pulse count equals rises depth3", pcnt3 - base3, rises);
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_fixed_latency();
      t_hold_high();
      t_random_offsets();
      done = 1'b1;
      report();
   end

endmodule